// File: doc/BRIEF.md
# Strap-Enabled Connectivity Test Tree

This block gives a board tester a way to check the solder joints of a set of pins without using the serial bus. A strap pin is sampled once, just after power-on reset is released. If the strap is high at that moment, the block enters a connectivity test mode. While the mode is on, a chain of 2-input NAND stages folds the test inputs into one result bit. That bit then drives a shared output pin in place of the pin's normal address function.

The mode ends on the first serial bus transaction, signalled by a one-cycle pulse from the bus engine. After that, only a new power-on reset can turn it on again. Neither the strap nor any other input can do so. Input 0 is the serial data pin and the highest input is the reset pin. A tester pulls them low one at a time in that order, with all the others held high, and watches the output fall.

Top module: `conn_test_tree`

## Requirements
- R1: While `por_n` is low, `test_mode_o` is 0 and `pin_o` equals `pin_normal_i`.
- R2: The mode is on from the first rising clock edge after `por_n` goes high if, at that edge, `strap_i` is 1 and `bus_first_i` is 0.
- R3: If `strap_i` is 0 at that first edge, `test_mode_o` stays 0 until the next power-on reset, whatever `strap_i` does afterwards.
- R4: A `bus_first_i` pulse ends the mode: `test_mode_o` is 0 from the following clock edge. A pulse at the capture edge stops the mode from starting.
- R5: Once the mode has ended, it stays off for any strap or bus activity. Only a fresh low pulse on `por_n` followed by a high strap turns it on again.
- R6: With every bit of `tree_in` at 1, `tree_o` is 1.
- R7: With exactly one bit of `tree_in` at 0, `tree_o` is 0. This holds for each position from bit 0 (serial data) to bit N_IN-1 (reset pin).
- R8: For any pattern on `tree_in`, `tree_o` is 1 exactly when all bits are 1, and it follows the inputs without a clock.
- R9: `pin_o` equals `tree_o` while `test_mode_o` is 1, and equals `pin_normal_i` otherwise.
- R10: After the capture edge, changes on `strap_i` have no effect on `test_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| strap_i | input | 1 | Sampled level of the test-enable strap pin |
| bus_first_i | input | 1 | One-cycle pulse marking a serial bus transaction |
| tree_in | input | N_IN | Tree inputs; bit 0 is serial data, the top bit is the reset pin |
| pin_normal_i | input | 1 | Normal address-strap value of the shared pin |
| pin_o | output | 1 | Shared pin value after the test mux |
| tree_o | output | 1 | Result of the NAND chain |
| test_mode_o | output | 1 | Test mode is active |

## Verification
The bench builds the block with N_IN = 12, the default. At that width all 4096 input patterns can be applied in full, so the tree is checked against its all-ones rule for every combination, not only for the single-low walk. The sticky mode register is exercised across three power-on cycles: strap high, strap low, and a bus pulse arriving at the capture edge. Together these reach the ways the mode can start, be refused, end, and return.

// File: rtl/conn_test_tree.sv
module conn_test_tree #(
  parameter int N_IN = 12
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            strap_i,
  input  logic            bus_first_i,
  input  logic [N_IN-1:0] tree_in,
  input  logic            pin_normal_i,
  output logic            pin_o,
  output logic            tree_o,
  output logic            test_mode_o
);

  logic armed;
  logic mode;
  logic [N_IN:0] chain;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      armed <= 1'b0;
      mode  <= 1'b0;
    end else if (!armed) begin
      armed <= 1'b1;
      mode  <= strap_i & ~bus_first_i;
    end else if (bus_first_i) begin
      mode  <= 1'b0;
    end
  end

  assign chain[0] = 1'b1;

  for (genvar k = 0; k < N_IN; k++) begin : g_stage
    logic nand_q;
    assign nand_q     = ~(chain[k] & tree_in[k]);
    assign chain[k+1] = ~nand_q;
  end

  assign tree_o      = chain[N_IN];
  assign test_mode_o = mode;
  assign pin_o       = mode ? tree_o : pin_normal_i;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!por_n)
    (!armed && strap_i && !bus_first_i) |=> mode);

  assert_strap_low_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!armed && !strap_i) |=> !mode);

  assert_exit_R4: assert property (@(posedge clk) disable iff (!por_n)
    (armed && bus_first_i) |=> !mode);

  assert_no_reentry_R5: assert property (@(posedge clk) disable iff (!por_n)
    (armed && !mode) |=> !mode);

  assert_ones_high_R6: assert property (@(posedge clk) disable iff (!por_n)
    (&tree_in) |-> tree_o);

  assert_zero_low_R8: assert property (@(posedge clk) disable iff (!por_n)
    !(&tree_in) |-> !tree_o);

  assert_armed_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
    armed |=> (armed && $stable(mode) || $past(bus_first_i)));

endmodule

// File: tb/test_conn_test_tree.sv
module test_conn_test_tree;
  localparam int N = 12;

  logic clk = 1'b0;
  logic por_n, strap_i, bus_first_i, pin_normal_i;
  logic [N-1:0] tree_in;
  logic pin_o, tree_o, test_mode_o;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  conn_test_tree #(.N_IN(N)) i_conn_test_tree (
    .clk(clk), .por_n(por_n), .strap_i(strap_i), .bus_first_i(bus_first_i),
    .tree_in(tree_in), .pin_normal_i(pin_normal_i), .pin_o(pin_o),
    .tree_o(tree_o), .test_mode_o(test_mode_o)
  );

  // {tree_in, expected tree_o}
  localparam logic [N:0] VEC [16] = '{
    {12'hFFF, 1'b1}, {12'hFFE, 1'b0}, {12'hFFD, 1'b0}, {12'hFFB, 1'b0},
    {12'hFF7, 1'b0}, {12'hFEF, 1'b0}, {12'hFDF, 1'b0}, {12'hFBF, 1'b0},
    {12'hF7F, 1'b0}, {12'hEFF, 1'b0}, {12'hDFF, 1'b0}, {12'hBFF, 1'b0},
    {12'h7FF, 1'b0}, {12'h000, 1'b0}, {12'hAAA, 1'b0}, {12'h555, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic power_up(input logic strap, input logic bus);
    por_n = 1'b0; strap_i = strap; bus_first_i = bus;
    repeat (2) tick();
    por_n = 1'b1;
    tick();
    bus_first_i = 1'b0;
  endtask

  initial begin
    por_n = 1'b0; strap_i = 1'b1; bus_first_i = 1'b0;
    tree_in = '1; pin_normal_i = 1'b0;
    repeat (3) tick();
    chk("R1 mode in reset", test_mode_o, 1'b0);
    chk("R1 pin in reset", pin_o, 1'b0);

    por_n = 1'b1;
    tick();
    chk("R2 mode after capture", test_mode_o, 1'b1);
    strap_i = 1'b0;
    repeat (3) tick();
    chk("R10 strap drop ignored", test_mode_o, 1'b1);

    for (int i = 0; i < 16; i++) begin
      tree_in = VEC[i][N:1];
      pin_normal_i = ~VEC[i][0];
      #1;
      chk(VEC[i][N:1] == '1 ? "R6 all ones" : "R7 table tree", tree_o, VEC[i][0]);
      chk("R9 pin shows tree", pin_o, VEC[i][0]);
    end

    for (int p = 0; p < (1 << N); p++) begin
      tree_in = p[N-1:0];
      #1;
      chk("R8 exhaustive", tree_o, (p == (1 << N) - 1));
    end

    tree_in = '1; pin_normal_i = 1'b0;
    bus_first_i = 1'b1;
    tick();
    bus_first_i = 1'b0;
    chk("R4 bus ends mode", test_mode_o, 1'b0);
    chk("R9 pin normal after exit", pin_o, 1'b0);
    pin_normal_i = 1'b1; tree_in = 12'h000; #1;
    chk("R9 pin follows normal", pin_o, 1'b1);

    strap_i = 1'b1;
    repeat (4) tick();
    chk("R5 no reentry", test_mode_o, 1'b0);

    tree_in = '1; pin_normal_i = 1'b0;
    power_up(1'b0, 1'b0);
    chk("R3 strap low at capture", test_mode_o, 1'b0);
    strap_i = 1'b1;
    repeat (3) tick();
    chk("R3 later strap high ignored", test_mode_o, 1'b0);

    power_up(1'b1, 1'b1);
    chk("R4 bus at capture blocks mode", test_mode_o, 1'b0);

    power_up(1'b1, 1'b0);
    chk("R5 power cycle reenables", test_mode_o, 1'b1);
    chk("R9 pin shows tree again", pin_o, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule